// File: doc/BRIEF.md
# Byte/Word Two-Operand ALU with Status Flags

This block is the two-operand execute unit of a 16-bit processor. Each cycle in which `op_valid` is high, it takes a 4-bit major opcode, a byte/word select, a source and a destination operand and an incoming carry. One clock later it presents the registered result, a write-back enable and updated zero, carry, negative and overflow flags. The flags stay in a status register between operations. Operand fetch, addressing and single-operand shifts belong to other blocks.

The operation set covers copy, binary add and subtract with and without carry, compare, packed-decimal add, bit test, bit clear, bit set, exclusive-or and and. Subtraction is formed as the destination plus the inverted source plus a carry term, so the carry flag reads as "no borrow". In byte mode only the low eight bits of each operand take part. The flags then come from bit 7, and the upper result byte is zero.

Top module: `bw_alu`

## Requirements
- R1: While `rst` is high and after it falls, before any operation: `result` = 0, `result_valid` = 0, `write_en` = 0, all four flags 0.
- R2: Opcodes: 0100 copy, 0101 add, 0110 add-with-carry, 0111 subtract-with-carry, 1000 subtract, 1001 compare, 1010 decimal add, 1011 bit test, 1100 bit clear, 1101 bit set, 1110 xor, 1111 and. Outputs register one cycle after `op_valid`. Copy gives `result` = src with `write_en` = 1.
- R3: Add gives dst + src. Add-with-carry gives dst + src + `carry_in`. C is the carry out of the operand width.
- R4: Subtract gives dst + ~src + 1. Subtract-with-carry gives dst + ~src + `carry_in`. C is the carry out of that sum.
- R5: Compare (dst − src) and bit test (src & dst) drive `result` and update the flags, with `write_en` = 0.
- R6: Decimal add works on each 4-bit digit from the lowest up. It forms dst digit + src digit + incoming carry, where the first incoming carry is `carry_in`. A digit sum above 9 gets 6 added, keeps its low 4 bits and carries 1 into the next digit. C is the carry out of the top digit, and V is 0.
- R7: Bit clear gives ~src & dst, bit set gives src | dst, xor gives src ^ dst, and and gives src & dst. All four write back.
- R8: With `byte_mode` = 1, operand bits 15:8 are ignored, `result[15:8]` = 0, N is bit 7, and C and V are taken at bit 7.
- R9: Z is set when the masked result is zero, and N is the masked result's top bit. For the four logic operations and bit test, C = not Z and V = 0.
- R10: For add and subtract forms, including compare, V is set when the two addends (the source after inversion for subtracts) share a sign that differs from the result's sign.
- R11: Copy leaves the flags unchanged. Opcodes 0000 to 0011 give `result` = 0 and `write_en` = 0 and leave the flags unchanged.
- R12: A cycle with `op_valid` low gives `result_valid` = 0 and `write_en` = 0 one cycle later and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| opcode | input | 4 | Major opcode |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| src | input | 16 | Source operand |
| dst | input | 16 | Destination operand |
| carry_in | input | 1 | Incoming carry for carry-using forms |
| result | output | 16 | Registered result |
| result_valid | output | 1 | Result registered from an operation |
| write_en | output | 1 | Result should be written back |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |

## Verification
On every cycle, the assertions check the handshake timing, the hold of the flags when idle and after a copy, the zero upper byte in byte mode, the suppressed write for compare and bit test, and the carry/zero relation of the logic operations. The arithmetic values themselves can only be shown by the bench's sweeps. These include the binary sums and their carries and overflows, the decimal digit correction chain and its carries, and the masking of the upper operand bits in byte mode. The bench checks them against a separate arithmetic model over every opcode, both widths and both carry inputs.

// File: rtl/bw_alu_pkg.sv
package bw_alu_pkg;
  typedef enum logic [3:0] {
    OP_MOV  = 4'h4,
    OP_ADD  = 4'h5,
    OP_ADDC = 4'h6,
    OP_SUBC = 4'h7,
    OP_SUB  = 4'h8,
    OP_CMP  = 4'h9,
    OP_DADD = 4'hA,
    OP_BIT  = 4'hB,
    OP_BIC  = 4'hC,
    OP_BIS  = 4'hD,
    OP_XOR  = 4'hE,
    OP_AND  = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/bw_alu_arith.sv
module bw_alu_arith #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              byte_mode,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W:0] full;
  logic            a_top, b_top, r_top;

  // operands arrive already masked to the active width
  assign full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};

  always_comb begin
    if (byte_mode) begin
      sum   = {{HALF{1'b0}}, full[HALF-1:0]};
      cout  = full[HALF];
      a_top = a[HALF-1];
      b_top = b[HALF-1];
      r_top = full[HALF-1];
    end else begin
      sum   = full[DATA_W-1:0];
      cout  = full[DATA_W];
      a_top = a[DATA_W-1];
      b_top = b[DATA_W-1];
      r_top = full[DATA_W-1];
    end
    ovf = (a_top == b_top) && (r_top != a_top);
  end
endmodule

// File: rtl/bw_alu_bcd.sv
module bw_alu_bcd #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              byte_mode,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  localparam int DIGITS = DATA_W / 4;

  logic [DIGITS:0] chain;
  assign chain[0] = cin;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [4:0] raw;
    logic [4:0] fixed;
    logic       over;
    assign raw   = {1'b0, a[4*g +: 4]} + {1'b0, b[4*g +: 4]} + {4'b0, chain[g]};
    assign over  = raw > 5'd9;
    assign fixed = over ? raw + 5'd6 : raw;
    assign sum[4*g +: 4] = fixed[3:0];
    assign chain[g+1]    = over;
  end

  assign cout = byte_mode ? chain[DIGITS/2] : chain[DIGITS];
endmodule

// File: rtl/bw_alu_logic.sv
module bw_alu_logic
  import bw_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] s,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] r
);
  always_comb begin
    case (op)
      OP_BIC:  r = ~s & d;
      OP_BIS:  r = s | d;
      OP_XOR:  r = s ^ d;
      default: r = s & d;
    endcase
  end
endmodule

// File: rtl/bw_alu.sv
module bw_alu
  import bw_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        opcode,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              write_en,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_n,
  output logic              flag_v
);
  localparam int HALF = DATA_W / 2;
  localparam logic [DATA_W-1:0] LOW_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [DATA_W-1:0] mask, s_m, d_m, ar_b;
  logic              ar_cin, is_sub;
  logic [DATA_W-1:0] ar_sum, dec_sum, lg_res;
  logic              ar_c, ar_v, dec_c;

  assign mask = byte_mode ? LOW_MASK : {DATA_W{1'b1}};
  assign s_m  = src & mask;
  assign d_m  = dst & mask;

  assign is_sub = (opcode == OP_SUB) || (opcode == OP_SUBC) || (opcode == OP_CMP);
  assign ar_b   = is_sub ? (~src & mask) : s_m;

  always_comb begin
    case (opcode)
      OP_ADDC, OP_SUBC: ar_cin = carry_in;
      OP_SUB, OP_CMP:   ar_cin = 1'b1;
      default:          ar_cin = 1'b0;
    endcase
  end

  bw_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a(d_m), .b(ar_b), .cin(ar_cin), .byte_mode(byte_mode),
    .sum(ar_sum), .cout(ar_c), .ovf(ar_v)
  );

  bw_alu_bcd #(.DATA_W(DATA_W)) u_bcd (
    .a(d_m), .b(s_m), .cin(carry_in), .byte_mode(byte_mode),
    .sum(dec_sum), .cout(dec_c)
  );

  bw_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op(opcode), .s(s_m), .d(d_m), .r(lg_res)
  );

  // result selection and write decision
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_wr, upd, use_ar, use_dec;

  always_comb begin
    nxt_res = '0;
    nxt_wr  = 1'b0;
    upd     = 1'b0;
    use_ar  = 1'b0;
    use_dec = 1'b0;
    case (opcode)
      OP_MOV: begin
        nxt_res = s_m;
        nxt_wr  = 1'b1;
      end
      OP_ADD, OP_ADDC, OP_SUBC, OP_SUB, OP_CMP: begin
        nxt_res = ar_sum;
        nxt_wr  = (opcode != OP_CMP);
        upd     = 1'b1;
        use_ar  = 1'b1;
      end
      OP_DADD: begin
        nxt_res = dec_sum & mask;
        nxt_wr  = 1'b1;
        upd     = 1'b1;
        use_dec = 1'b1;
      end
      OP_BIT, OP_BIC, OP_BIS, OP_XOR, OP_AND: begin
        nxt_res = lg_res;
        nxt_wr  = (opcode != OP_BIT);
        upd     = 1'b1;
      end
      default: ;
    endcase
  end

  // flag formation from the selected result
  alu_flags_t nxt_flags, flags_q;
  logic       res_zero, res_top;

  assign res_zero = (nxt_res == '0);
  assign res_top  = byte_mode ? nxt_res[HALF-1] : nxt_res[DATA_W-1];

  always_comb begin
    nxt_flags.z = res_zero;
    nxt_flags.n = res_top;
    if (use_ar) begin
      nxt_flags.c = ar_c;
      nxt_flags.v = ar_v;
    end else if (use_dec) begin
      nxt_flags.c = dec_c;
      nxt_flags.v = 1'b0;
    end else begin
      nxt_flags.c = ~res_zero;
      nxt_flags.v = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      result_valid <= 1'b0;
      write_en     <= 1'b0;
      flags_q      <= '0;
    end else begin
      result_valid <= op_valid;
      write_en     <= op_valid && nxt_wr;
      if (op_valid) result <= nxt_res;
      if (op_valid && upd) flags_q <= nxt_flags;
    end
  end

  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_n = flags_q.n;
  assign flag_v = flags_q.v;
endmodule

// File: rtl/bw_alu_chk.sv
module bw_alu_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [3:0]        opcode,
  input logic              byte_mode,
  input logic [DATA_W-1:0] result,
  input logic              result_valid,
  input logic              write_en,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_n,
  input logic              flag_v
);
  localparam int HALF = DATA_W / 2;

  logic [3:0] flags;
  logic       is_logic;
  assign flags    = {flag_z, flag_c, flag_n, flag_v};
  assign is_logic = opcode >= 4'hB;

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> result_valid);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!result_valid && !write_en && $stable(flags)));

  assert_test_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (opcode == 4'h9 || opcode == 4'hB)) |=> !write_en);

  assert_byte_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && byte_mode) |=> (result[DATA_W-1:HALF] == '0));

  assert_copy_keeps_flags_R11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (opcode == 4'h4 || opcode < 4'h4)) |=> $stable(flags));

  assert_logic_carry_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_logic) |=> (flag_c == !flag_z && !flag_v));

  assert_zero_matches_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && opcode >= 4'h5) |=> (flag_z == (result == '0)));
endmodule

bind bw_alu bw_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bw_alu_bench.sv
`timescale 1ns/1ps
module bw_alu_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  opcode;
  logic        byte_mode;
  logic [15:0] src, dst;
  logic        carry_in;
  logic [15:0] result;
  logic        result_valid, write_en, flag_z, flag_c, flag_n, flag_v;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model state
  bit e_z, e_c, e_n, e_v;

  always #2 clk = ~clk;

  bw_alu u_bw_alu (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
    .byte_mode(byte_mode), .src(src), .dst(dst), .carry_in(carry_in),
    .result(result), .result_valid(result_valid), .write_en(write_en),
    .flag_z(flag_z), .flag_c(flag_c), .flag_n(flag_n), .flag_v(flag_v)
  );

  localparam logic [15:0] PATS [16] = '{
    16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h00FF, 16'h0100, 16'h1234,
    16'h9999, 16'h0999, 16'h5A5A, 16'hA5A5, 16'h0009, 16'h8001, 16'h4321, 16'hFFFE};

  function automatic string res_tag(int op);
    if (op == 4)              return "R2";
    if (op == 5 || op == 6)   return "R3";
    if (op == 7 || op == 8)   return "R4";
    if (op == 9 || op == 11)  return "R5";
    if (op == 10)             return "R6";
    if (op >= 12)             return "R7";
    return "R11";
  endfunction

  function automatic string flag_tag(int op);
    if (op == 4 || op < 4)    return "R11";
    if (op >= 5 && op <= 9)   return "R10";
    if (op == 10)             return "R6";
    return "R9";
  endfunction

  task automatic check(string tag, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // apply one operation and compare against the arithmetic model
  task automatic apply(int op, bit bm, int s, int d, bit ci);
    int mask, w, sb, a, b, cin, sum, er, car, k, t;
    bit ewr, upd, c, v;
    string bt;
    mask = bm ? 255 : 65535;
    w    = bm ? 8 : 16;
    sb   = 1 << (w - 1);
    er = 0; ewr = 0; upd = 0; c = 0; v = 0;
    a = d & mask;
    if (op == 4) begin
      er = s & mask; ewr = 1;
    end else if (op >= 5 && op <= 9) begin
      b   = (op >= 7) ? ((~s) & mask) : (s & mask);
      cin = (op == 5) ? 0 : (op == 6 || op == 7) ? int'(ci) : 1;
      sum = a + b + cin;
      er  = sum & mask;
      c   = ((sum >> w) & 1) != 0;
      v   = ((a ^ er) & (b ^ er) & sb) != 0;
      ewr = (op != 9); upd = 1;
    end else if (op == 10) begin
      car = int'(ci);
      for (k = 0; k < w / 4; k++) begin
        t = ((d >> (4*k)) & 15) + ((s >> (4*k)) & 15) + car;
        if (t > 9) begin t = t + 6; car = 1; end else car = 0;
        er = er | ((t & 15) << (4*k));
      end
      c = (car != 0); ewr = 1; upd = 1;
    end else if (op >= 11) begin
      b = s & mask;
      case (op)
        12: er = (~b) & a & mask;
        13: er = b | a;
        14: er = b ^ a;
        default: er = b & a;
      endcase
      c = (er != 0); ewr = (op != 11); upd = 1;
    end
    if (upd) begin
      e_z = (er == 0); e_n = ((er & sb) != 0); e_c = c; e_v = v;
    end
    op_valid = 1'b1; opcode = op[3:0]; byte_mode = bm;
    src = s[15:0]; dst = d[15:0]; carry_in = ci;
    @(negedge clk);
    op_valid = 1'b0;
    bt = bm ? " R8" : "";
    check({res_tag(op), bt, " result"}, {15'b0, result_valid, write_en, result},
          {15'b0, 1'b1, ewr, er[15:0]});
    check({flag_tag(op), bt, " flags"}, {flag_z, flag_c, flag_n, flag_v},
          {e_z, e_c, e_n, e_v});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_valid = 1'b0; opcode = 4'h0; byte_mode = 1'b0;
    src = '0; dst = '0; carry_in = 1'b0;
    e_z = 0; e_c = 0; e_n = 0; e_v = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", {result_valid, write_en, result, flag_z, flag_c, flag_n, flag_v}, 0);

    // exhaustive sweep over ops, widths, carries and operand patterns
    for (int op = 4; op < 16; op++)
      for (int bm = 0; bm < 2; bm++)
        for (int ci = 0; ci < 2; ci++)
          for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++)
              apply(op, bm[0], int'(PATS[i]), int'(PATS[j]), ci[0]);

    // R11 undefined opcodes: no write, zero result, flags held
    apply(5, 1'b0, 16'h8000, 16'h8000, 1'b0);
    for (int op = 0; op < 4; op++) apply(op, 1'b0, 16'h1234, 16'h5678, 1'b1);
    apply(4, 1'b1, 16'hABCD, 16'h0000, 1'b0);

    // R12 idle cycle: no valid, no write, flags stay
    @(negedge clk);
    check("R12 idle", {result_valid, write_en, flag_z, flag_c, flag_n, flag_v},
          {1'b0, 1'b0, e_z, e_c, e_n, e_v});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule